// File: doc/BRIEF.md
# Byte Exchange Serial Master

This block moves single bytes between a network controller and a host microcontroller over a three-wire synchronous serial link. The block is the clock master: it derives the serial clock from its faster system clock with an integer divider. The host cannot start a shift itself. It asks for one with a rising edge on one of two handshake inputs. The data request input means the host has loaded a byte for the block to fetch. The status request input asks for a control/status swap, in which the host's control byte comes in while the block's status byte goes out.

Every transfer is one full-duplex shift of eight bits, most significant bit first, with SPI mode 0 timing. The clock idles low. The outgoing bit changes on the falling clock edge and the incoming bit is sampled on the rising edge. While a transfer runs, the active-low busy output is low and the output enable for the clock and data pins is high. At all other times the output enable is low, so the pad drivers float those pins.

When a shift ends, the received byte leaves on a one-cycle valid pulse, together with a flag that tells which request it served. Back-pressure acts only at the start of a transfer. A data fetch begins only in a cycle where the consumer signals ready, and it is held pending until then. A status exchange never waits for ready. There is no handshake after the pulse: the consumer must take the byte in the cycle that valid is high.

Top module: `bx_serial_master`

## Requirements
- R1: Each half period of the serial clock lasts HALF = CLK_HZ/(2*SCK_HZ) system cycles. A transfer has exactly 8 rising clock edges, and busy stays low for 16*HALF cycles.
- R2: Bits go out most significant bit first. The data output changes only at a falling clock edge or at the start of a transfer, and it holds steady while the clock is high. Input bits are sampled on the rising edge and assembled most significant bit first.
- R3: A status exchange (flag out_is_ctrl_o = 1) sends the value on status_i as it was in the start cycle and delivers the byte received from the host.
- R4: A data fetch (flag out_is_ctrl_o = 0) sends 8'h00 and delivers the byte received from the host.
- R5: serial_oe_o is high and busy_n_o is low exactly while a transfer runs. Outside a transfer, sck_o is low.
- R6: While reset is active and after it, busy_n_o = 1, serial_oe_o = 0, sck_o = 0 and out_valid_o = 0.
- R7: A request is taken only on a rising edge of its input. A level held high starts exactly one transfer, and a falling edge starts none.
- R8: When both requests are pending while the block is idle, the status exchange goes first.
- R9: A request edge that arrives during a transfer is held and served after that transfer ends.
- R10: A data fetch starts only in a cycle where out_ready_i is high. A status exchange starts whatever out_ready_i is.
- R11: out_valid_o is a one-cycle pulse in the cycle after the last falling clock edge, at the same time busy_n_o returns high. It carries out_data_o and out_is_ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_req_i | input | 1 | Host data request; a rising edge asks for a fetch |
| stat_req_i | input | 1 | Host status request; a rising edge asks for an exchange |
| status_i | input | 8 | Status byte sent during an exchange |
| sin_i | input | 1 | Serial data from the host |
| sck_o | output | 1 | Serial clock to the host |
| sout_o | output | 1 | Serial data to the host |
| serial_oe_o | output | 1 | Output enable for the sck_o and sout_o pads |
| busy_n_o | output | 1 | Active-low transfer activity |
| out_ready_i | input | 1 | Consumer can take a fetched byte |
| out_valid_o | output | 1 | One-cycle pulse: received byte is valid |
| out_data_o | output | 8 | Received byte |
| out_is_ctrl_o | output | 1 | 1 = status exchange, 0 = data fetch |

## Verification
Two of the block's functions can act in the same cycle. The first case is the capture of a new request edge in the cycle where arbitration takes a pending request or a transfer finishes. The second is both request edges arriving in the same cycle. The bench raises both request inputs on the same clock, and it also raises one request in the middle of a running shift. It then judges the order and content of the transfers that follow, using a host-side model that records every byte and every flag. A level held high past the end of its transfer shows whether the capture and the clearing of a pending request interfere, because exactly one transfer must result.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic {
    XFER_DATA = 1'b0,
    XFER_CTRL = 1'b1
  } xfer_kind_e;

  localparam int REQ_DATA = 0;
  localparam int REQ_STAT = 1;
  localparam int REQ_N    = 2;
endpackage

// File: rtl/bx_req_sync.sv
module bx_req_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], req_i[g]};
    end
    assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]); // R7
  end
endmodule

// File: rtl/bx_sck_gen.sv
module bx_sck_gen #(
  parameter int HALF  = 4,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (start_i) begin
      cnt   <= RELOAD;
      sck_q <= 1'b0;
    end else if (run_i) begin
      if (cnt == '0) begin
        cnt   <= RELOAD;
        sck_q <= ~sck_q;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = run_i && (cnt == '0) && !sck_q;
  assign fall_o = run_i && (cnt == '0) &&  sck_q;

  AST_SCK_LOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i) |-> !sck_o); // R5
endmodule

// File: rtl/bx_shifter.sv
module bx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sin_i,
  output logic         sout_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_val_i;
      rx_q <= '0;
    end else begin
      if (fall_i) tx_q <= {tx_q[W-2:0], 1'b0};
      if (rise_i) rx_q <= {rx_q[W-2:0], sin_i};
    end
  end

  assign sout_o = tx_q[W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/bx_serial_master.sv
module bx_serial_master
  import bx_pkg::*;
#(
  parameter int CLK_HZ      = 8_000_000,
  parameter int SCK_HZ      = 1_000_000,
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_req_i,
  input  logic         stat_req_i,
  input  logic [W-1:0] status_i,
  input  logic         sin_i,
  output logic         sck_o,
  output logic         sout_o,
  output logic         serial_oe_o,
  output logic         busy_n_o,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         out_is_ctrl_o
);
  localparam int HALF  = (CLK_HZ / (2 * SCK_HZ)) < 1 ? 1 : CLK_HZ / (2 * SCK_HZ);
  localparam int CNT_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  logic [REQ_N-1:0] req_rise;
  logic             stat_pend, data_pend;
  logic             active;
  xfer_kind_e       kind;
  logic [BIT_W-1:0] bitn;
  logic             take_ctrl, take_data, start;
  logic             sck_rise, sck_fall;
  logic [W-1:0]     rx_byte;
  logic [W-1:0]     load_val;

  bx_req_sync #(.N(REQ_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  ({stat_req_i, data_req_i}),
    .rise_o (req_rise)
  );

  // Arbitration: status exchange outranks data fetch; fetch needs consumer room
  assign take_ctrl = !active && stat_pend;
  assign take_data = !active && !stat_pend && data_pend && out_ready_i;
  assign start     = take_ctrl || take_data;
  assign load_val  = take_ctrl ? status_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      data_pend <= 1'b0;
    end else begin
      stat_pend <= req_rise[REQ_STAT] | (stat_pend & ~take_ctrl);
      data_pend <= req_rise[REQ_DATA] | (data_pend & ~take_data);
    end
  end

  bx_sck_gen #(.HALF(HALF), .CNT_W(CNT_W)) i_sck (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .run_i   (active),
    .sck_o   (sck_o),
    .rise_o  (sck_rise),
    .fall_o  (sck_fall)
  );

  bx_shifter #(.W(W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start),
    .load_val_i (load_val),
    .rise_i     (sck_rise),
    .fall_i     (sck_fall),
    .sin_i      (sin_i),
    .sout_o     (sout_o),
    .rx_o       (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active        <= 1'b0;
      kind          <= XFER_DATA;
      bitn          <= '0;
      out_valid_o   <= 1'b0;
      out_data_o    <= '0;
      out_is_ctrl_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (start) begin
        active <= 1'b1;
        kind   <= take_ctrl ? XFER_CTRL : XFER_DATA;
        bitn   <= '0;
      end else if (sck_fall) begin
        if (bitn == LAST_BIT) begin
          active        <= 1'b0;
          out_valid_o   <= 1'b1;
          out_data_o    <= rx_byte;
          out_is_ctrl_o <= (kind == XFER_CTRL);
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  assign serial_oe_o = active;
  assign busy_n_o    = ~active;

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_oe_o |-> !sck_o); // R5
  AST_SOUT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sout_o)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o); // R11
  AST_VALID_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $rose(busy_n_o)); // R11
  AST_FETCH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_n_o) && kind == XFER_DATA) |-> $past(out_ready_i)); // R10
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && data_pend && !active) |=> (kind == XFER_CTRL)); // R8
endmodule

// File: tb/test_bx_serial_master.sv
module test_bx_serial_master;
  localparam int CLK_HZ = 8_000_000;
  localparam int SCK_HZ = 1_000_000;
  localparam int W      = 8;
  localparam int HALF   = CLK_HZ / (2 * SCK_HZ);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         data_req = 1'b0, stat_req = 1'b0;
  logic [W-1:0] status = '0;
  logic         sin = 1'b0;
  logic         sck, sout, oe, busy_n;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_is_ctrl;

  always #5 clk = ~clk;

  bx_serial_master #(.CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .W(W)) i_bx_serial_master (
    .clk(clk), .rst_n(rst_n), .data_req_i(data_req), .stat_req_i(stat_req),
    .status_i(status), .sin_i(sin), .sck_o(sck), .sout_o(sout),
    .serial_oe_o(oe), .busy_n_o(busy_n), .out_ready_i(out_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_is_ctrl_o(out_is_ctrl)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Host-side model
  bit           kq[$];
  bit           kh[$];
  logic [W-1:0] ctrl_byte = '0, data_byte = '0;
  bit           cur_kind;
  logic [W-1:0] cur_host, cur_exp, cap;
  int           idx, rises, busy_len, sck_hi;
  int           starts = 0, dones = 0, idle_bad = 0;
  logic         prev_busy = 1'b1, prev_sck = 1'b0;

  function automatic logic [W-1:0] exp_sent(input bit ctrl, input logic [W-1:0] st);
    return ctrl ? st : '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (cur_kind) chk(out_data == cur_host, "R3", "exchange rx byte", out_data, cur_host);
        else          chk(out_data == cur_host, "R4", "fetch rx byte", out_data, cur_host);
        chk(out_is_ctrl == cur_kind, "R11", "kind flag", out_is_ctrl, cur_kind);
        chk(cap == cur_exp, "R2", "sent byte msb first", cap, cur_exp);
        chk(rises == W && busy_len == 16 * HALF && sck_hi == 8 * HALF, "R1",
            "rises/busy/high cycles", rises * 10000 + busy_len * 100 + sck_hi,
            W * 10000 + 16 * HALF * 100 + 8 * HALF);
        kh.push_back(out_is_ctrl);
        dones++;
      end
      if (busy_n && (oe || sck)) idle_bad++;
      if (!busy_n && !oe) idle_bad++;
      if (!busy_n && prev_busy) begin
        starts++;
        if (kq.size() == 0) begin
          chk(1'b0, "R7", "unexpected transfer start", 1, 0);
          cur_kind = 1'b0;
        end else begin
          cur_kind = kq.pop_front();
        end
        cur_host = cur_kind ? ctrl_byte : data_byte;
        cur_exp  = exp_sent(cur_kind, status);
        idx = 0; rises = 0; busy_len = 0; sck_hi = 0; cap = '0;
        sin <= cur_host[W-1];
      end
      if (!busy_n) busy_len++;
      if (sck) sck_hi++;
      if (sck && !prev_sck) begin
        cap = {cap[W-2:0], sout};
        rises++;
      end
      if (!sck && prev_sck && !busy_n) begin
        idx++;
        if (idx < W) sin <= cur_host[W-1-idx];
      end
      prev_busy = busy_n;
      prev_sck  = sck;
    end
  end

  task automatic pulse(input bit s, input bit d);
    @(negedge clk);
    if (s) stat_req = 1'b1;
    if (d) data_req = 1'b1;
    repeat (3) @(negedge clk);
    stat_req = 1'b0;
    data_req = 1'b0;
  endtask

  task automatic wait_dones(input int n);
    while (dones < n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0, base;
    s0 = $urandom(32'd4711);
    repeat (5) @(negedge clk);
    chk(busy_n == 1'b1 && oe == 1'b0 && sck == 1'b0 && out_valid == 1'b0, "R6",
        "state in reset", {busy_n, oe, sck, out_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1 && oe == 1'b0 && out_valid == 1'b0, "R6", "state after reset",
        {busy_n, oe, out_valid}, 3'b100);

    // directed exchange and fetch
    status = 8'hA5; ctrl_byte = 8'h3C; kq.push_back(1'b1); pulse(1'b1, 1'b0); wait_dones(1);
    data_byte = 8'hC3; kq.push_back(1'b0); pulse(1'b0, 1'b1); wait_dones(2);
    status = 8'h80; ctrl_byte = 8'h01; kq.push_back(1'b1); pulse(1'b1, 1'b0); wait_dones(3);

    // back-pressure holds a fetch, not an exchange
    out_ready = 1'b0; data_byte = 8'h7E; kq.push_back(1'b0);
    base = starts; pulse(1'b0, 1'b1); repeat (100) @(negedge clk);
    chk(starts == base, "R10", "fetch held while not ready", starts, base);
    out_ready = 1'b1; wait_dones(4);
    out_ready = 1'b0; status = 8'h5A; ctrl_byte = 8'hE7; kq.push_back(1'b1);
    pulse(1'b1, 1'b0); wait_dones(5);
    chk(dones == 5, "R10", "exchange ignores ready", dones, 5);
    out_ready = 1'b1;

    // both requests in one cycle
    kh.delete(); ctrl_byte = 8'h96; data_byte = 8'h69; status = 8'hF0;
    kq.push_back(1'b1); kq.push_back(1'b0); pulse(1'b1, 1'b1); wait_dones(7);
    chk(kh.size() == 2 && kh[0] == 1'b1 && kh[1] == 1'b0, "R8", "status served first",
        kh.size() == 2 ? {kh[0], kh[1]} : 0, 2'b10);

    // request during a transfer
    ctrl_byte = 8'h11; data_byte = 8'hEE; status = 8'h0F;
    kq.push_back(1'b1); pulse(1'b1, 1'b0);
    while (busy_n) @(negedge clk);
    repeat (10) @(negedge clk);
    kq.push_back(1'b0); pulse(1'b0, 1'b1); wait_dones(9);
    chk(dones == 9 && kq.size() == 0, "R9", "mid-transfer request served", dones, 9);

    // level held high starts one transfer only
    base = starts; ctrl_byte = 8'hB4; kq.push_back(1'b1);
    @(negedge clk); stat_req = 1'b1; wait_dones(10); repeat (150) @(negedge clk);
    stat_req = 1'b0; repeat (40) @(negedge clk);
    chk(starts == base + 1, "R7", "held level and fall start one transfer", starts, base + 1);

    // constrained random mix
    for (int i = 0; i < 25; i++) begin
      bit k;
      k = 1'($urandom % 2);
      status    = W'($urandom);
      ctrl_byte = W'($urandom);
      data_byte = W'($urandom);
      kq.push_back(k);
      pulse(k, !k);
      wait_dones(11 + i);
    end

    chk(idle_bad == 0, "R5", "enable/clock outside transfers", idle_bad, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule